// File: doc/BRIEF.md
# Burst Memory Address Predictor

This block sits between a processor bus interface and an external memory controller during cache-line bursts. When the processor opens a burst, the block captures the line address and the cycle-type qualifiers. For every following data transfer it then supplies the full memory address before the processor drives it, so the memory controller can start each access early.

The low word-select bits are not produced by a linear increment. They follow the processor's interleaved order: the doubleword index is the saved starting doubleword XORed with a step count, and the halfword bit toggles within each doubleword. A 16-byte line takes eight halfword transfers. The block also drives both halfword byte-enable strobes. On every transfer but the final one the high strobe is predicted active. On the final transfer it is decoded from the processor's own byte enables. A cacheability flag is decoded when the burst opens, and a one-cycle pulse marks the end of the burst.

Top module: `burst_addr_predictor`

## Requirements
- R1: A synchronous active-low reset makes the block idle: `burst_active` 0, `burst_done` 0, all captured fields 0, so `mem_addr` reads 0, `cacheable` reads 0 and both byte-enable strobes read 1.
- R2: `start_strobe` high while the block is idle captures `cpu_addr`, and `burst_active` is 1 from the next cycle. `mem_addr[31:4]` then equals the captured `cpu_addr[31:4]` for the whole burst.
- R3: Let S be the number of acknowledged transfers since burst start (S = 0 to 7) and LA the captured `cpu_addr[3:2]`. Then `mem_addr[3:2]` = LA XOR S[2:1] and `mem_addr[1]` = S[0].
- R4: On the eighth transfer of a full line, `mem_addr[3:2]` is the bitwise inverse of LA and `mem_addr[1]` is 1.
- R5: `q_mem_io`, `q_write` and `q_data` show the `mem_io`, `write` and `data` inputs captured at burst start. They stay constant until the next burst starts.
- R6: `mem_lo_be_n` is 0 whenever `burst_active` is 1 and 1 when the block is idle.
- R7: While the block is active, `mem_hi_be_n` is 0 unless `last_n` is 0. When `last_n` is 0 it equals `cpu_be_hi_n[1]` (byte lane 3) if `mem_addr[1]` is 1, and `cpu_be_hi_n[0]` (byte lane 1) if `mem_addr[1]` is 0. When the block is idle it is 1.
- R8: `cacheable` is 1 for the burst exactly when the `pcd`, `lock_n` and `ken_n` values captured at burst start were 0, 1 and 0.
- R9: `xfer_ack` high with `last_n` low ends the burst. On the next cycle `burst_active` is 0 and `burst_done` is 1, for that one cycle only.
- R10: `start_strobe` asserted during an active burst is ignored. The address, qualifiers and cacheability stay as captured.
- R11: A cycle without `xfer_ack` leaves the transfer count, and so `mem_addr`, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_strobe | input | 1 | Burst start marker, active high |
| cpu_addr | input | 30 | Processor address bits 31:2 |
| mem_io | input | 1 | Memory/IO qualifier |
| write | input | 1 | Write/read qualifier |
| data | input | 1 | Data/code qualifier |
| pcd | input | 1 | Page cache disable |
| lock_n | input | 1 | Locked cycle, active low |
| ken_n | input | 1 | Cache enable, active low |
| xfer_ack | input | 1 | Data transfer acknowledge |
| last_n | input | 1 | Final transfer marker, active low |
| cpu_be_hi_n | input | 2 | Processor byte enables for lanes 3 and 1, active low |
| mem_addr | output | 31 | Predicted memory address bits 31:1 |
| mem_lo_be_n | output | 1 | Low halfword byte strobe, active low |
| mem_hi_be_n | output | 1 | High halfword byte strobe, active low |
| q_mem_io | output | 1 | Captured memory/IO qualifier |
| q_write | output | 1 | Captured write/read qualifier |
| q_data | output | 1 | Captured data/code qualifier |
| cacheable | output | 1 | Burst is cacheable |
| burst_active | output | 1 | Burst in progress |
| burst_done | output | 1 | One-cycle end-of-burst pulse |

## Verification
The bench starts a burst from each of the four starting doublewords. A predictor that counted linearly, or that used the live address bits instead of the captured ones, would give wrong word-select bits from the third transfer on. The wrong value would be clearest on the final address, where both saved bits must appear inverted. Stalls without acknowledge are placed inside each burst, and a stray start strobe is given mid-burst. A design that advanced without acknowledge, or that recaptured on that strobe, would shift or corrupt the sequence. All eight combinations of the three cacheability inputs are exercised, along with short bursts whose final byte enables vary. This catches an inverted decode term and a high strobe that stays predicted on the final transfer.

// File: rtl/burst_pred_pkg.sv
// Package: shared constants and the interleaved word-select function.
// Assumes a line of LINE_XFERS halfword transfers, two per doubleword.
package burst_pred_pkg;

    localparam int BUS_W      = 32;
    localparam int LINE_XFERS = 8;

    // Word select for transfer step: doubleword index XORed with saved bits,
    // halfword bit taken from the step's low bit.
    function automatic logic [2:0] word_select(input logic [1:0] la, input logic [2:0] step);
        return {la ^ step[2:1], step[0]};
    endfunction

endpackage

// File: rtl/burst_capture.sv
// Captures the line address, saved word-select bits, qualifiers and the
// cacheability decode when a burst opens. Assumes load is only raised while
// the sequencer is idle; fields hold until the next load.
module burst_capture #(
    parameter int ADDR_W = burst_pred_pkg::BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              active,
    input  logic [ADDR_W-1:2] cpu_addr,
    input  logic              mem_io,
    input  logic              write,
    input  logic              data,
    input  logic              pcd,
    input  logic              lock_n,
    input  logic              ken_n,
    output logic [ADDR_W-1:4] line_addr,
    output logic [1:0]        saved_ws,
    output logic              q_mem_io,
    output logic              q_write,
    output logic              q_data,
    output logic              cacheable
);

    // Capture every burst-constant field on load, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_addr <= '0;
            saved_ws  <= '0;
            q_mem_io  <= 1'b0;
            q_write   <= 1'b0;
            q_data    <= 1'b0;
            cacheable <= 1'b0;
        end else if (load) begin
            line_addr <= cpu_addr[ADDR_W-1:4];
            saved_ws  <= cpu_addr[3:2];
            q_mem_io  <= mem_io;
            q_write   <= write;
            q_data    <= data;
            cacheable <= ~pcd & lock_n & ~ken_n;
        end
    end

    // R10: nothing captured changes while a burst runs
    p_hold_fields_r10: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> ($stable(line_addr) && $stable(saved_ws) && $stable(q_mem_io)
                    && $stable(q_write) && $stable(q_data) && $stable(cacheable)));

    // R8: cacheability follows the inputs seen at the load edge
    p_cache_decode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cacheable == ($past(pcd) == 1'b0 && $past(lock_n) == 1'b1
                                && $past(ken_n) == 1'b0)));

endmodule

// File: rtl/burst_sequencer.sv
// Tracks burst progress: active flag, transfer step and end pulse.
// Assumes xfer_ack only matters while active; last_n qualifies the final ack.
module burst_sequencer #(
    parameter int LINE_XFERS = burst_pred_pkg::LINE_XFERS,
    localparam int STEP_W    = $clog2(LINE_XFERS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              xfer_ack,
    input  logic              last_n,
    output logic              active,
    output logic [STEP_W-1:0] step,
    output logic              done,
    output logic              load
);

    // Open a burst only from idle.
    always_comb load = start & ~active;

    // Advance step per acknowledge; close the burst on the final acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            step   <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                step <= '0;
                if (start) active <= 1'b1;
            end else if (xfer_ack) begin
                if (!last_n) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    step <= step + STEP_W'(1);
                end
            end
        end
    end

    // R9: final acknowledge closes the burst and raises the pulse
    p_end_of_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && xfer_ack && !last_n) |=> (!active && done));

    // R9: end pulse lasts a single cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: no acknowledge, no step change
    p_step_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !xfer_ack) |=> $stable(step));

endmodule

// File: rtl/burst_addr_gen.sv
// Forms the predicted address and the halfword byte strobes from the captured
// fields and the current step. Purely combinational; assumes step counts
// acknowledged transfers since burst start.
module burst_addr_gen #(
    parameter int ADDR_W      = burst_pred_pkg::BUS_W,
    parameter int LINE_XFERS  = burst_pred_pkg::LINE_XFERS,
    localparam int STEP_W     = $clog2(LINE_XFERS)
) (
    input  logic              active,
    input  logic [STEP_W-1:0] step,
    input  logic [ADDR_W-1:4] line_addr,
    input  logic [1:0]        saved_ws,
    input  logic              last_n,
    input  logic [1:0]        cpu_be_hi_n,
    output logic [ADDR_W-1:1] mem_addr,
    output logic              mem_lo_be_n,
    output logic              mem_hi_be_n
);

    logic [2:0] ws;

    // Interleaved word select from saved bits and step.
    always_comb ws = burst_pred_pkg::word_select(saved_ws, 3'(step));

    // Assemble the address: line bits straight through, word bits predicted.
    always_comb mem_addr = {line_addr, ws};

    // Byte strobes: low always on in a burst; high predicted except on the last.
    always_comb begin
        mem_lo_be_n = ~active;
        if (!active)      mem_hi_be_n = 1'b1;
        else if (!last_n) mem_hi_be_n = ws[0] ? cpu_be_hi_n[1] : cpu_be_hi_n[0];
        else              mem_hi_be_n = 1'b0;
    end

endmodule

// File: rtl/burst_addr_predictor.sv
// Top: burst memory address predictor. Connects the sequencer, the capture
// registers and the address generator. Assumes the processor holds last_n
// and the byte enables valid on every acknowledged transfer.
module burst_addr_predictor #(
    parameter int ADDR_W     = burst_pred_pkg::BUS_W,
    parameter int LINE_XFERS = burst_pred_pkg::LINE_XFERS,
    localparam int STEP_W    = $clog2(LINE_XFERS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_strobe,
    input  logic [ADDR_W-1:2] cpu_addr,
    input  logic              mem_io,
    input  logic              write,
    input  logic              data,
    input  logic              pcd,
    input  logic              lock_n,
    input  logic              ken_n,
    input  logic              xfer_ack,
    input  logic              last_n,
    input  logic [1:0]        cpu_be_hi_n,
    output logic [ADDR_W-1:1] mem_addr,
    output logic              mem_lo_be_n,
    output logic              mem_hi_be_n,
    output logic              q_mem_io,
    output logic              q_write,
    output logic              q_data,
    output logic              cacheable,
    output logic              burst_active,
    output logic              burst_done
);

    logic              load;
    logic [STEP_W-1:0] step;
    logic [ADDR_W-1:4] line_addr;
    logic [1:0]        saved_ws;

    burst_sequencer #(.LINE_XFERS(LINE_XFERS)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start_strobe), .xfer_ack(xfer_ack),
        .last_n(last_n), .active(burst_active), .step(step), .done(burst_done),
        .load(load)
    );

    burst_capture #(.ADDR_W(ADDR_W)) cap_i (
        .clk(clk), .rst_n(rst_n), .load(load), .active(burst_active),
        .cpu_addr(cpu_addr), .mem_io(mem_io), .write(write), .data(data),
        .pcd(pcd), .lock_n(lock_n), .ken_n(ken_n), .line_addr(line_addr),
        .saved_ws(saved_ws), .q_mem_io(q_mem_io), .q_write(q_write),
        .q_data(q_data), .cacheable(cacheable)
    );

    burst_addr_gen #(.ADDR_W(ADDR_W), .LINE_XFERS(LINE_XFERS)) gen_i (
        .active(burst_active), .step(step), .line_addr(line_addr),
        .saved_ws(saved_ws), .last_n(last_n), .cpu_be_hi_n(cpu_be_hi_n),
        .mem_addr(mem_addr), .mem_lo_be_n(mem_lo_be_n), .mem_hi_be_n(mem_hi_be_n)
    );

    // R4: the last step of a full line lands on the inverted saved doubleword, high half
    p_final_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && step == STEP_W'(LINE_XFERS - 1))
            |-> (mem_addr[3:2] == ~saved_ws && mem_addr[1]));

    // R6: low strobe tracks the burst flag
    p_lo_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        burst_active |-> !mem_lo_be_n);

endmodule

// File: tb/burst_addr_predictor_tb_top.sv
// Bench: behavioural reference model updated each rising edge, compared
// against the DUT on every falling edge.
module burst_addr_predictor_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_strobe = 1'b0;
    logic [31:2] cpu_addr = '0;
    logic        mem_io = 1'b0, write = 1'b0, data = 1'b0;
    logic        pcd = 1'b0, lock_n = 1'b1, ken_n = 1'b0;
    logic        xfer_ack = 1'b0, last_n = 1'b1;
    logic [1:0]  cpu_be_hi_n = 2'b00;
    logic [31:1] mem_addr;
    logic        mem_lo_be_n, mem_hi_be_n, q_mem_io, q_write, q_data;
    logic        cacheable, burst_active, burst_done;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;
    bit in_reset = 1'b1;

    // reference model state
    bit          m_act = 0, m_done = 0, m_cach = 0, m_mio = 0, m_wr = 0, m_dc = 0;
    int          m_k = 0;
    logic [1:0]  m_la = '0;
    logic [27:0] m_line = '0;

    always #4ns clk = ~clk;

    burst_addr_predictor dut_i (
        .clk(clk), .rst_n(rst_n), .start_strobe(start_strobe), .cpu_addr(cpu_addr),
        .mem_io(mem_io), .write(write), .data(data), .pcd(pcd), .lock_n(lock_n),
        .ken_n(ken_n), .xfer_ack(xfer_ack), .last_n(last_n), .cpu_be_hi_n(cpu_be_hi_n),
        .mem_addr(mem_addr), .mem_lo_be_n(mem_lo_be_n), .mem_hi_be_n(mem_hi_be_n),
        .q_mem_io(q_mem_io), .q_write(q_write), .q_data(q_data), .cacheable(cacheable),
        .burst_active(burst_active), .burst_done(burst_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", in_reset ? "R1" : req, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model and the current inputs.
    task automatic compare();
        logic [1:0] ws;
        logic       hb;
        ws = m_la ^ 2'(m_k >> 1);
        check("R2", 32'(mem_addr[31:4]), 32'(m_line));
        check((m_act && m_k == 7) ? "R4" : "R3", 32'(mem_addr[3:1]), 32'({ws, m_k[0]}));
        check("R5", 32'({q_mem_io, q_write, q_data}), 32'({m_mio, m_wr, m_dc}));
        check("R6", 32'(mem_lo_be_n), 32'(!m_act));
        if (!m_act)       hb = 1'b1;
        else if (!last_n) hb = m_k[0] ? cpu_be_hi_n[1] : cpu_be_hi_n[0];
        else              hb = 1'b0;
        check("R7", 32'(mem_hi_be_n), 32'(hb));
        check("R8", 32'(cacheable), 32'(m_cach));
        check("R9", 32'({burst_active, burst_done}), 32'({m_act, m_done}));
    endtask

    // One cycle: inputs already set at falling edge; compare, then update model at rise.
    task automatic tick();
        #1ns compare();
        @(posedge clk);
        if (!rst_n) begin
            m_act = 0; m_k = 0; m_done = 0; m_la = '0; m_line = '0;
            m_mio = 0; m_wr = 0; m_dc = 0; m_cach = 0;
        end else begin
            m_done = 0;
            if (!m_act) begin
                m_k = 0;
                if (start_strobe) begin
                    m_act = 1; m_line = cpu_addr[31:4]; m_la = cpu_addr[3:2];
                    m_mio = mem_io; m_wr = write; m_dc = data;
                    m_cach = (pcd == 0) && (lock_n == 1) && (ken_n == 0);
                end
            end else if (xfer_ack) begin
                if (!last_n) begin m_act = 0; m_done = 1; end
                else m_k = (m_k + 1) % 8;
            end
        end
        @(negedge clk);
        start_strobe = 0; xfer_ack = 0; last_n = 1;
    endtask

    // Open a burst with given address and cacheability inputs.
    task automatic open_burst(input logic [29:0] a, input logic [2:0] cq, input logic [2:0] qual);
        start_strobe = 1; cpu_addr = a;
        {pcd, lock_n, ken_n} = cq;
        {mem_io, write, data} = qual;
        tick();
        cpu_addr = ~a;              // live address changes must not leak (R2, R3)
        {pcd, lock_n, ken_n} = ~cq; // nor cacheability inputs (R8)
        {mem_io, write, data} = ~qual;
    endtask

    // One transfer, optionally preceded by stall cycles (R11) and a stray strobe (R10).
    task automatic xfer(input bit last, input int stalls, input logic [1:0] be);
        for (int s = 0; s < stalls; s++) begin
            start_strobe = (s == 0);
            cpu_be_hi_n = ~be;
            tick();
        end
        xfer_ack = 1; last_n = !last; cpu_be_hi_n = be;
        tick();
    endtask

    initial begin
        @(negedge clk);
        tick(); tick();                 // R1: reset state
        rst_n = 1; in_reset = 0;
        tick();
        // R3/R4: full line from every starting doubleword
        for (int s = 0; s < 4; s++) begin
            open_burst({28'h1234560 + 28'(s * 7), 2'(s)}, 3'(s), 3'(s + 3));
            for (int i = 0; i < 8; i++)
                xfer(i == 7, (i % 3 == 1) ? 2 : 0, 2'(i));
            tick();                     // R9: done pulse visible, then idle
            tick();
        end
        // R8: all cacheability combinations, with short bursts and final strobes (R7)
        for (int c = 0; c < 8; c++) begin
            open_burst({28'h0ABCDEF ^ 28'(c), 2'(c)}, 3'(c), 3'(c));
            for (int i = 0; i <= c % 3; i++)
                xfer(i == c % 3, 0, 2'(c));
            tick();
        end
        // R1: reset mid-burst returns to idle
        open_burst(30'h3FFFFFFF, 3'b010, 3'b111);
        xfer(0, 0, 2'b11);
        rst_n = 0; in_reset = 1;
        tick(); tick();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule